// File: doc/BRIEF.md
# Indirect Register Access Window

This block gives a host, through a narrow 32-bit register port, reach into a much larger internal register file. The host first loads a word address into a pointer register. It then writes or reads a data register, and the block forwards that access to an internal register bus at the pointed-to word. A separate enable bit in a host control register gates all forwarding. While that bit is clear, data-register accesses never reach the internal bus.

The host port takes one-cycle request pulses with a byte offset, a write flag, write data and four byte enables. Each request is answered one cycle later by an acknowledge, which carries read data when the request was a read. The internal side is a 16-bit word-address bus. It has a write strobe with byte enables and a read strobe, and read data is expected on the cycle after the read strobe.

Top module: `ind_reg_window`

## Requirements
- R1: The pointer register at host offset 0x78 stores host data bits [17:2] as the internal word address, updating only the byte lanes whose enable is set (lane n covers data bits 8n+7..8n). It reads back with bits [1:0] and [31:18] as zero and resets to zero.
- R2: The control register at host offset 0x68 holds the indirect-enable flag in bit 7, written through byte lane 0. It resets to zero and reads back with all other bits zero.
- R3: With the enable set, a host write to offset 0x80 with at least one byte enable produces exactly one internal write strobe in the same cycle. The strobe carries the pointer as the address, the host data, and the host byte enables, so that only enabled lanes change.
- R4: A host write to offset 0x80 with all four byte enables clear produces no internal write.
- R5: With the enable set, a host read of offset 0x80 asserts the internal read strobe for exactly one cycle at the pointer address. The acknowledge on the next cycle returns the internal read data.
- R6: With the enable clear, writes to offset 0x80 cause no internal write, and reads of offset 0x80 cause no internal read and return zero.
- R7: Every host request gets exactly one acknowledge, on the cycle after it. Reads of any other offset return zero.
- R8: The pointer keeps its value across data accesses, so repeated data accesses reach the same internal word until the pointer is written again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| host_req_i | input | 1 | One-cycle host access request |
| host_we_i | input | 1 | Request is a write |
| host_off_i | input | 8 | Host byte offset |
| host_wdata_i | input | 32 | Host write data |
| host_be_i | input | 4 | Host byte enables |
| host_ack_o | output | 1 | Access complete, one cycle after request |
| host_rdata_o | output | 32 | Read data, valid with acknowledge |
| int_addr_o | output | 16 | Internal word address (pointer) |
| int_we_o | output | 1 | Internal write strobe |
| int_be_o | output | 4 | Internal write byte enables |
| int_wdata_o | output | 32 | Internal write data |
| int_re_o | output | 1 | Internal read strobe |
| int_rdata_i | input | 32 | Internal read data, one cycle after read strobe |

## Verification
The hardest case to reach from the ports is a data-register write that lands in the middle of a sequence of partial pointer updates and enable toggles. Proving it touched only the intended lanes of the intended word takes a later, separate read through the same window. The bench models the internal register file behind the bus and keeps a shadow copy updated only by the rules above. Random mixes of pointer writes (with random reserved bits and lanes), data writes with random byte enables including none, reads and enable flips then let every later read expose any misrouted or ungated access.

// File: rtl/ind_win_pkg.sv
package ind_win_pkg;
  localparam int HOST_OW     = 8;
  localparam int DW          = 32;
  localparam int BEW         = DW / 8;
  localparam int IAW         = 16;
  localparam int PTR_LO      = 2;
  localparam int CTRL_EN_BIT = 7;

  localparam logic [HOST_OW-1:0] OFF_CTRL = 8'h68;
  localparam logic [HOST_OW-1:0] OFF_PTR  = 8'h78;
  localparam logic [HOST_OW-1:0] OFF_DATA = 8'h80;

  typedef enum logic [1:0] {SEL_NONE, SEL_CTRL, SEL_PTR, SEL_DATA} sel_e;
endpackage

// File: rtl/ind_win_decode.sv
module ind_win_decode
  import ind_win_pkg::*;
(
  input  logic [HOST_OW-1:0] off_i,
  output sel_e               sel_o
);
  always_comb begin
    unique case (off_i)
      OFF_CTRL: sel_o = SEL_CTRL;
      OFF_PTR:  sel_o = SEL_PTR;
      OFF_DATA: sel_o = SEL_DATA;
      default:  sel_o = SEL_NONE;
    endcase
  end
endmodule

// File: rtl/ind_win_regs.sv
module ind_win_regs
  import ind_win_pkg::*;
(
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           wr_ctrl_i,
  input  logic           wr_ptr_i,
  input  logic [DW-1:0]  wdata_i,
  input  logic [BEW-1:0] be_i,
  output logic           en_o,
  output logic [IAW-1:0] ptr_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_o <= 1'b0;
    end else if (wr_ctrl_i && be_i[CTRL_EN_BIT/8]) begin
      en_o <= wdata_i[CTRL_EN_BIT];
    end
  end

  // pointer bit i maps to host bit i+PTR_LO; each bit follows its own lane enable
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ptr_o <= '0;
    end else if (wr_ptr_i) begin
      for (int i = 0; i < IAW; i++) begin
        if (be_i[(i+PTR_LO)/8]) ptr_o[i] <= wdata_i[i+PTR_LO];
      end
    end
  end
endmodule

// File: rtl/ind_win_fwd.sv
module ind_win_fwd
  import ind_win_pkg::*;
(
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           req_i,
  input  logic           we_i,
  input  sel_e           sel_i,
  input  logic           en_i,
  input  logic [BEW-1:0] be_i,
  input  logic [IAW-1:0] ptr_i,
  input  logic [DW-1:0]  local_rdata_i,
  input  logic [DW-1:0]  int_rdata_i,
  output logic           int_we_o,
  output logic           int_re_o,
  output logic           ack_o,
  output logic [DW-1:0]  rdata_o
);
  logic          data_hit;
  logic          pend_q;
  logic [DW-1:0] rd_q;

  assign data_hit = req_i && (sel_i == SEL_DATA) && en_i;
  assign int_we_o = data_hit && we_i && (|be_i);
  assign int_re_o = data_hit && !we_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ack_o  <= 1'b0;
      pend_q <= 1'b0;
      rd_q   <= '0;
    end else begin
      ack_o  <= req_i;
      pend_q <= int_re_o;
      if (req_i) rd_q <= we_i ? '0 : local_rdata_i;
    end
  end

  // internal bus returns data the cycle after the strobe
  assign rdata_o = pend_q ? int_rdata_i : rd_q;

  logic unused_ptr;
  assign unused_ptr = ^ptr_i;
endmodule

// File: rtl/ind_reg_window.sv
module ind_reg_window
  import ind_win_pkg::*;
(
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           host_req_i,
  input  logic           host_we_i,
  input  logic [7:0]     host_off_i,
  input  logic [31:0]    host_wdata_i,
  input  logic [3:0]     host_be_i,
  output logic           host_ack_o,
  output logic [31:0]    host_rdata_o,
  output logic [15:0]    int_addr_o,
  output logic           int_we_o,
  output logic [3:0]     int_be_o,
  output logic [31:0]    int_wdata_o,
  output logic           int_re_o,
  input  logic [31:0]    int_rdata_i
);
  sel_e           sel;
  logic           en;
  logic [IAW-1:0] ptr;
  logic [DW-1:0]  local_rdata;

  ind_win_decode u_dec (.off_i(host_off_i), .sel_o(sel));

  ind_win_regs u_regs (
    .clk_i, .rst_ni,
    .wr_ctrl_i (host_req_i && host_we_i && sel == SEL_CTRL),
    .wr_ptr_i  (host_req_i && host_we_i && sel == SEL_PTR),
    .wdata_i   (host_wdata_i),
    .be_i      (host_be_i),
    .en_o      (en),
    .ptr_o     (ptr)
  );

  always_comb begin
    local_rdata = '0;
    unique case (sel)
      SEL_CTRL: local_rdata[CTRL_EN_BIT] = en;
      SEL_PTR:  local_rdata[PTR_LO +: IAW] = ptr;
      default:  local_rdata = '0;
    endcase
  end

  ind_win_fwd u_fwd (
    .clk_i, .rst_ni,
    .req_i         (host_req_i),
    .we_i          (host_we_i),
    .sel_i         (sel),
    .en_i          (en),
    .be_i          (host_be_i),
    .ptr_i         (ptr),
    .local_rdata_i (local_rdata),
    .int_rdata_i   (int_rdata_i),
    .int_we_o      (int_we_o),
    .int_re_o      (int_re_o),
    .ack_o         (host_ack_o),
    .rdata_o       (host_rdata_o)
  );

  assign int_addr_o  = ptr;
  assign int_be_o    = host_be_i;
  assign int_wdata_o = host_wdata_i;
endmodule

// File: rtl/ind_reg_window_chk.sv
module ind_reg_window_chk (
  input logic        clk_i,
  input logic        rst_ni,
  input logic        host_req_i,
  input logic        host_we_i,
  input logic [7:0]  host_off_i,
  input logic        host_ack_o,
  input logic [15:0] int_addr_o,
  input logic        int_we_o,
  input logic [3:0]  int_be_o,
  input logic        int_re_o
);
  AST_WR_NEEDS_BE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    int_we_o |-> int_be_o != 4'h0); // R4
  AST_WR_FROM_HOST: assert property (@(posedge clk_i) disable iff (!rst_ni)
    int_we_o |-> host_req_i && host_we_i && host_off_i == 8'h80); // R3
  AST_RD_ONE_CYCLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    int_re_o |=> !int_re_o && host_ack_o); // R5
  AST_NO_DUAL_STROBE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(int_we_o && int_re_o)); // R3
  AST_ACK_AFTER_REQ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    host_req_i |=> host_ack_o); // R7
  AST_ACK_ONLY_REQ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !host_req_i |=> !host_ack_o); // R7
  AST_PTR_HELD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(host_req_i && host_we_i && host_off_i == 8'h78) |=> $stable(int_addr_o)); // R8
endmodule

bind ind_reg_window ind_reg_window_chk u_chk (.*);

// File: tb/ind_reg_window_test.sv
module ind_reg_window_test;
  logic        clk = 0;
  logic        rst_n = 0;
  logic        req = 0, we = 0;
  logic [7:0]  off = 0;
  logic [31:0] wdata = 0;
  logic [3:0]  be = 0;
  logic        ack;
  logic [31:0] rdata;
  logic [15:0] iaddr;
  logic        iwe, ire;
  logic [3:0]  ibe;
  logic [31:0] iwdata;
  logic [31:0] irdata = 0;

  int tests = 0, fails = 0;
  int wr_seen = 0, rd_seen = 0;
  logic [31:0] mem [256];
  logic [31:0] exp_mem [256];
  logic        exp_en;
  logic [15:0] exp_ptr;

  always #2 clk = ~clk;

  ind_reg_window uut (
    .clk_i(clk), .rst_ni(rst_n), .host_req_i(req), .host_we_i(we), .host_off_i(off),
    .host_wdata_i(wdata), .host_be_i(be), .host_ack_o(ack), .host_rdata_o(rdata),
    .int_addr_o(iaddr), .int_we_o(iwe), .int_be_o(ibe), .int_wdata_o(iwdata),
    .int_re_o(ire), .int_rdata_i(irdata)
  );

  // internal register file model
  always @(posedge clk) begin
    if (iwe) begin
      wr_seen++;
      for (int b = 0; b < 4; b++) if (ibe[b]) mem[iaddr[7:0]][8*b +: 8] <= iwdata[8*b +: 8];
    end
    if (ire) begin
      rd_seen++;
      irdata <= mem[iaddr[7:0]];
    end
  end

  function automatic logic [31:0] merge(logic [31:0] old, logic [31:0] d, logic [3:0] m);
    for (int b = 0; b < 4; b++) if (m[b]) old[8*b +: 8] = d[8*b +: 8];
    return old;
  endfunction

  function automatic logic [15:0] ptr_upd(logic [15:0] p, logic [31:0] d, logic [3:0] m);
    for (int i = 0; i < 16; i++) if (m[(i+2)/8]) p[i] = d[i+2];
    return p;
  endfunction

  task automatic check(string r, logic [31:0] act, logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: got %h expected %h", r, act, exp);
    end
  endtask

  task automatic op(input logic w, input logic [7:0] o, input logic [3:0] m,
                    input logic [31:0] d, output logic [31:0] rd);
    @(negedge clk);
    req = 1; we = w; off = o; be = m; wdata = d;
    @(negedge clk);
    req = 0;
    check("R7 ack", {31'b0, ack}, 32'd1);
    rd = rdata;
    if (w) begin
      if (o == 8'h78) exp_ptr = ptr_upd(exp_ptr, d, m);
      if (o == 8'h68 && m[0]) exp_en = d[7];
      if (o == 8'h80 && exp_en) exp_mem[exp_ptr[7:0]] = merge(exp_mem[exp_ptr[7:0]], d, m);
    end
  endtask

  function automatic logic [31:0] exp_read(logic [7:0] o);
    case (o)
      8'h68:   return {24'b0, exp_en, 7'b0};
      8'h78:   return {14'b0, exp_ptr, 2'b00};
      8'h80:   return exp_en ? exp_mem[exp_ptr[7:0]] : 32'h0;
      default: return 32'h0;
    endcase
  endfunction

  initial begin
    #400000;
    fails++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    logic [31:0] rd;
    int w0, r0;
    void'($urandom(32'd1234));
    for (int i = 0; i < 256; i++) begin
      mem[i] = 32'h1000_0000 + i;
      exp_mem[i] = 32'h1000_0000 + i;
    end
    exp_en = 0; exp_ptr = 0;
    repeat (3) @(negedge clk);
    check("R7 ack idle in reset", {31'b0, ack}, 32'd0);
    rst_n = 1;

    op(0, 8'h78, 4'hF, 0, rd); check("R1 ptr reset", rd, 32'h0);
    op(0, 8'h68, 4'hF, 0, rd); check("R2 ctrl reset", rd, 32'h0);

    op(1, 8'h78, 4'hF, 32'hFFFF_FFFF, rd);
    op(0, 8'h78, 4'hF, 0, rd); check("R1 reserved zero", rd, 32'h0003_FFFC);
    op(1, 8'h78, 4'b0010, 32'h0, rd);
    op(0, 8'h78, 4'hF, 0, rd); check("R1 lane write", rd, 32'h0003_00FC);
    op(1, 8'h68, 4'hF, 32'hFFFF_FF7F, rd);
    op(0, 8'h68, 4'hF, 0, rd); check("R2 bit7 only", rd, 32'h0);

    // disabled: nothing forwarded
    op(1, 8'h78, 4'hF, 32'h5 << 2, rd);
    w0 = wr_seen; r0 = rd_seen;
    op(1, 8'h80, 4'hF, 32'hDEAD_BEEF, rd);
    op(0, 8'h80, 4'hF, 0, rd);
    check("R6 disabled read zero", rd, 32'h0);
    check("R6 no internal write", wr_seen - w0, 0);
    check("R6 no internal read", rd_seen - r0, 0);

    op(1, 8'h68, 4'b0001, 32'h80, rd);
    op(0, 8'h68, 4'hF, 0, rd); check("R2 enable set", rd, 32'h80);
    w0 = wr_seen;
    op(1, 8'h80, 4'hF, 32'hCAFE_F00D, rd);
    check("R3 one write", wr_seen - w0, 1);
    op(0, 8'h80, 4'hF, 0, rd); check("R5 read back", rd, 32'hCAFE_F00D);
    op(1, 8'h80, 4'b0001, 32'h1111_1111, rd);
    op(0, 8'h80, 4'hF, 0, rd); check("R3 partial lanes", rd, 32'hCAFE_F011);
    w0 = wr_seen;
    op(1, 8'h80, 4'b0000, 32'h0, rd);
    check("R4 no write", wr_seen - w0, 0);
    op(0, 8'h80, 4'hF, 0, rd); check("R4 data kept", rd, 32'hCAFE_F011);
    op(0, 8'h80, 4'hF, 0, rd); check("R8 same word", rd, 32'hCAFE_F011);
    op(0, 8'h40, 4'hF, 0, rd); check("R7 unmapped zero", rd, 32'h0);

    for (int n = 0; n < 400; n++) begin
      int k;
      logic [31:0] e;
      k = $urandom_range(0, 9);
      if (k < 2) op(1, 8'h78, 4'hF, ($urandom & 32'hFFFC_0003) | ($urandom_range(0, 255) << 2), rd);
      else if (k == 2) op(1, 8'h68, 4'h1, ($urandom_range(0, 3) != 0) ? 32'h80 : 32'h0, rd);
      else if (k < 6) begin
        w0 = wr_seen;
        be = 4'($urandom);
        op(1, 8'h80, be, $urandom, rd);
        check("R3 R4 R6 write count", wr_seen - w0, (exp_en && be != 0) ? 1 : 0);
      end else begin
        logic [7:0] o;
        o = (k < 9) ? 8'h80 : ((k % 2) ? 8'h78 : 8'h68);
        e = exp_read(o);
        op(0, o, 4'hF, 0, rd);
        check("R5 R8 random read", rd, e);
      end
    end

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule